// File: doc/BRIEF.md
# Bit-Stuffed Link Receive Front End

This block sits directly behind the serial receive pin of a bit-oriented synchronous link. It takes one line bit per cycle in which `bit_en` is high. It counts runs of consecutive ones on the raw line and removes the zero that a transmitter inserts after five ones. It recognises the six-ones flag that marks frame boundaries and spots runs of seven or more ones. After reset the receiver hunts and delivers nothing until it sees a flag. From then on it emits destuffed payload bits with a one-cycle `out_valid` strobe. It also feeds them into a small receive shift register for the byte stage that follows.

Accepted bits pass through a seven-slot holding window and then a three-slot delay. The window always contains every bit of a flag at the moment the flag's closing zero arrives, so the window can be discarded and no flag bit is ever delivered. A run of seven ones has two meanings, chosen by `loop_mode`. In normal operation it is an abort: pending bits are thrown away and the receiver returns to hunting. In loop operation it is an end-of-poll marker: pending bits are thrown away but the receiver stays synchronised.

Top module: `hdlc_rx_front`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters hunt state: `in_sync`, `out_valid`, `flag_seen`, `abort_seen` and `eop_seen` are 0 and `rx_shift` is all zeros.
- R2: A zero that follows exactly five consecutive line ones is deleted. It produces no `out_valid` and does not appear in the delivered stream, and the ones run restarts from zero.
- R3: A line sequence of six ones followed by a zero is a flag. In the cycle after its closing zero is accepted, `flag_seen` pulses for one cycle and `in_sync` is 1.
- R4: While in hunt state (`in_sync` = 0), `out_valid` stays 0 whatever the line carries.
- R5: With `loop_mode` = 0, a seventh consecutive one pulses `abort_seen` and clears `in_sync`. Every bit not yet delivered is discarded, and no data is delivered until a later flag.
- R6: With `loop_mode` = 1, a seventh consecutive one pulses `eop_seen` instead of `abort_seen`. `in_sync` is left unchanged and every bit not yet delivered is discarded.
- R7: No bit belonging to a flag is ever delivered. The delivered stream between two flags equals the transmitter's payload in order, and back-to-back flags deliver nothing.
- R8: At most one of `flag_seen`, `abort_seen` and `eop_seen` is high in any cycle.
- R9: Cycles with `bit_en` = 0 are ignored. They produce no pulse, no `out_valid`, and no change of `in_sync` or `rx_shift`, whatever `bit_in` carries.
- R10: Each delivered bit enters `rx_shift` at bit 7 while the older bits move one place toward bit 0. After N ≥ 8 deliveries, `rx_shift[k]` holds delivered bit N-8+k, counting from 0.
- R11: After a run of seven or more ones, further ones and the zero that ends the run are discarded. Line bits after that zero are handled as ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Raw received line bit |
| loop_mode | input | 1 | 0: seven ones mean abort; 1: seven ones mean end-of-poll |
| out_valid | output | 1 | One-cycle strobe for a delivered payload bit |
| out_bit | output | 1 | Delivered payload bit, meaningful with `out_valid` |
| rx_shift | output | 8 | Receive shift register of delivered bits, newest at bit 7 |
| in_sync | output | 1 | 1 after a flag, 0 while hunting |
| flag_seen | output | 1 | One-cycle pulse on flag detection |
| abort_seen | output | 1 | One-cycle pulse on abort (normal mode) |
| eop_seen | output | 1 | One-cycle pulse on end-of-poll (loop mode) |

## Verification
Several properties are checked on every cycle. Delivery only happens while synchronised. Events are mutually exclusive and each maps to the mode that produced it. An abort leaves the hunt state and an end-of-poll keeps the sync state. Nothing moves on a cycle without `bit_en`, and each delivered bit lands at the top of the shift register. Zero deletion, the hiding of flag bits and the discard of pending bits after a long run of ones all depend on the order of a whole bit sequence. Only the bench scenarios can show these: they compare the delivered stream against the payload the bench stuffed itself, including frames full of ones, frames with idle gaps and frames split by seven-ones runs in both modes.

// File: rtl/hdlc_rx_pkg.sv
// Shared definitions for the bit-stuffed receive front end.
// Assumes: one line bit per qualified cycle; ones runs are counted on raw bits.
package hdlc_rx_pkg;

    // What the ones tracker decides about the bit currently on the line
    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,  // ordinary bit, enters the holding window
        ACT_DROP = 2'd1,  // stuffed zero or part of a long run, vanishes
        ACT_FLAG = 2'd2,  // closing zero of a flag
        ACT_LONG = 2'd3   // seventh consecutive one: abort or end-of-poll
    } bit_act_e;

    // One slot of a holding pipeline: the bit and whether it may be delivered
    typedef struct packed {
        logic data;
        logic tag;
    } slot_t;

endpackage

// File: rtl/hdlc_ones_tracker.sv
// Counts consecutive raw ones and classifies every qualified line bit.
// Assumes: STUFF_RUN ones trigger zero deletion; one more one makes a flag
// body, and one beyond that is a long run. The count saturates so that runs
// of any length stay classified. The classification output is combinational
// from the current count and bit_in; the caller qualifies it with bit_en.
module hdlc_ones_tracker #(
    parameter int STUFF_RUN = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bit_en,
    input  logic                   bit_in,
    output hdlc_rx_pkg::bit_act_e  act
);
    import hdlc_rx_pkg::*;

    localparam int FLAG_RUN = STUFF_RUN + 1;
    localparam int CNT_MAX  = FLAG_RUN + 1;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] ones_q;

    // Classify the present line bit against the current run length
    always_comb begin
        act = ACT_KEEP;
        if (bit_in) begin
            if (ones_q == CNT_W'(FLAG_RUN))
                act = ACT_LONG;
            else if (ones_q > CNT_W'(FLAG_RUN))
                act = ACT_DROP;
        end else begin
            if (ones_q == CNT_W'(STUFF_RUN))
                act = ACT_DROP;
            else if (ones_q == CNT_W'(FLAG_RUN))
                act = ACT_FLAG;
            else if (ones_q > CNT_W'(FLAG_RUN))
                act = ACT_DROP;
        end
    end

    // Track the run of consecutive ones, saturating past a long run
    always_ff @(posedge clk) begin
        if (!rst_n)
            ones_q <= '0;
        else if (bit_en) begin
            if (!bit_in)
                ones_q <= '0;
            else if (ones_q != CNT_W'(CNT_MAX))
                ones_q <= ones_q + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_bit_pipe.sv
// Fixed-depth shift pipeline of tagged bits. A push shifts every slot by one
// and exposes the oldest slot on exit_* (combinational, valid in the push
// cycle). A flush clears every tag so that pending bits are never delivered.
// Assumes: push and flush are never asserted together; DEPTH >= 2.
module hdlc_bit_pipe #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_bit,
    input  logic push_tag,
    input  logic flush,
    output logic exit_bit,
    output logic exit_tag
);
    import hdlc_rx_pkg::*;

    slot_t [DEPTH-1:0] slots_q;
    slot_t [DEPTH-1:0] slots_d;
    slot_t             new_slot;

    assign new_slot = '{data: push_bit, tag: push_tag};
    assign exit_bit = slots_q[DEPTH-1].data;
    assign exit_tag = slots_q[DEPTH-1].tag;

    // Next pipeline contents: invalidate on flush, shift in on push
    always_comb begin
        slots_d = slots_q;
        if (flush) begin
            for (int i = 0; i < DEPTH; i++)
                slots_d[i].tag = 1'b0;
        end else if (push) begin
            slots_d = {slots_q[DEPTH-2:0], new_slot};
        end
    end

    // Hold the pipeline slots
    always_ff @(posedge clk) begin
        if (!rst_n)
            slots_q <= '0;
        else
            slots_q <= slots_d;
    end

endmodule

// File: rtl/hdlc_rx_front.sv
// Receive front end for a bit-stuffed synchronous link. Raw bits are
// classified by the ones tracker; ordinary bits enter a window as long as a
// flag body and then a short delay, and leave as delivered data only if they
// were tagged while synchronised and never flushed. A flag flushes the
// window (which holds exactly the flag's bits) and synchronises; a long run
// flushes both stages and, in normal mode, returns to hunting.
// Assumes: loop_mode is static within a frame; rx_shift is consumed elsewhere.
module hdlc_rx_front #(
    parameter int STUFF_RUN = 5,
    parameter int DLY_DEPTH = 3,
    parameter int SHIFT_W   = 8,
    parameter bit LSB_FIRST = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               bit_in,
    input  logic               loop_mode,
    output logic               out_valid,
    output logic               out_bit,
    output logic [SHIFT_W-1:0] rx_shift,
    output logic               in_sync,
    output logic               flag_seen,
    output logic               abort_seen,
    output logic               eop_seen
);
    import hdlc_rx_pkg::*;

    // A flag body is the leading zero plus STUFF_RUN+1 ones
    localparam int WIN_DEPTH = STUFF_RUN + 2;

    typedef enum logic {ST_HUNT = 1'b0, ST_SYNC = 1'b1} rx_state_e;

    bit_act_e  act;
    rx_state_e state_q;
    logic      insert, flag_ev, long_ev;
    logic      win_bit, win_tag, dly_bit, dly_tag;

    hdlc_ones_tracker #(.STUFF_RUN(STUFF_RUN)) u_ones (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .act    (act)
    );

    // Qualified per-bit events
    always_comb begin
        insert  = bit_en && (act == ACT_KEEP);
        flag_ev = bit_en && (act == ACT_FLAG);
        long_ev = bit_en && (act == ACT_LONG);
    end

    hdlc_bit_pipe #(.DEPTH(WIN_DEPTH)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (insert),
        .push_bit (bit_in),
        .push_tag (state_q == ST_SYNC),
        .flush    (flag_ev || long_ev),
        .exit_bit (win_bit),
        .exit_tag (win_tag)
    );

    hdlc_bit_pipe #(.DEPTH(DLY_DEPTH)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (insert),
        .push_bit (win_bit),
        .push_tag (win_tag),
        .flush    (long_ev),
        .exit_bit (dly_bit),
        .exit_tag (dly_tag)
    );

    // Hunt / sync state: a flag synchronises, a normal-mode long run unlocks
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_HUNT;
        else if (flag_ev)
            state_q <= ST_SYNC;
        else if (long_ev && !loop_mode)
            state_q <= ST_HUNT;
    end

    // Event pulses and the delivered-bit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_seen  <= 1'b0;
            abort_seen <= 1'b0;
            eop_seen   <= 1'b0;
            out_valid  <= 1'b0;
            out_bit    <= 1'b0;
        end else begin
            flag_seen  <= flag_ev;
            abort_seen <= long_ev && !loop_mode;
            eop_seen   <= long_ev && loop_mode;
            out_valid  <= insert && dly_tag;
            if (insert && dly_tag)
                out_bit <= dly_bit;
        end
    end

    // Receive shift register; the variant picks the shift direction
    generate
        if (LSB_FIRST) begin : g_shift_lsb
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rx_shift <= '0;
                else if (insert && dly_tag)
                    rx_shift <= {dly_bit, rx_shift[SHIFT_W-1:1]};
            end
        end else begin : g_shift_msb
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rx_shift <= '0;
                else if (insert && dly_tag)
                    rx_shift <= {rx_shift[SHIFT_W-2:0], dly_bit};
            end
        end
    endgenerate

    assign in_sync = (state_q == ST_SYNC);

endmodule

// File: rtl/hdlc_rx_front_chk.sv
// Cycle-level properties of the receive front end, observed at its ports.
// Assumes the default newest-at-top shift direction.
module hdlc_rx_front_chk #(
    parameter int SHIFT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bit_en,
    input logic               loop_mode,
    input logic               out_valid,
    input logic               out_bit,
    input logic [SHIFT_W-1:0] rx_shift,
    input logic               in_sync,
    input logic               flag_seen,
    input logic               abort_seen,
    input logic               eop_seen
);

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_seen, abort_seen, eop_seen})); // R8

    AST_FLAG_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_seen |-> in_sync); // R3

    AST_ABORT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        abort_seen |-> (!in_sync && !$past(loop_mode))); // R5

    AST_EOP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        eop_seen |-> ($past(loop_mode) && $stable(in_sync))); // R6

    AST_NO_DATA_HUNTING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_sync); // R4

    AST_ACTIVITY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || flag_seen || abort_seen || eop_seen) |-> $past(bit_en)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> ($stable(in_sync) && $stable(rx_shift))); // R9

    AST_SHIFT_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rx_shift[SHIFT_W-1] == out_bit)); // R10

endmodule

bind hdlc_rx_front hdlc_rx_front_chk #(.SHIFT_W(SHIFT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .loop_mode  (loop_mode),
    .out_valid  (out_valid),
    .out_bit    (out_bit),
    .rx_shift   (rx_shift),
    .in_sync    (in_sync),
    .flag_seen  (flag_seen),
    .abort_seen (abort_seen),
    .eop_seen   (eop_seen)
);

// File: tb/hdlc_rx_front_test.sv
// Directed scenarios for the receive front end; each task checks itself.
module hdlc_rx_front_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       loop_mode = 1'b0;
    logic       out_valid, out_bit, in_sync, flag_seen, abort_seen, eop_seen;
    logic [7:0] rx_shift;

    int total = 0;
    int fails = 0;
    int got_n, flag_n, abort_n, eop_n;
    logic got [0:255];
    logic exp [0:255];

    always #2 clk = ~clk;  // 250 MHz

    hdlc_rx_front uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .loop_mode(loop_mode), .out_valid(out_valid), .out_bit(out_bit),
        .rx_shift(rx_shift), .in_sync(in_sync), .flag_seen(flag_seen),
        .abort_seen(abort_seen), .eop_seen(eop_seen)
    );

    // Monitor: sample outputs 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (out_valid && got_n < 256) begin
                got[got_n] = out_bit;
                got_n++;
            end
            if (flag_seen)  flag_n++;
            if (abort_seen) abort_n++;
            if (eop_seen)   eop_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk);
        bit_en = 1'b0;
        got_n = 0; flag_n = 0; abort_n = 0; eop_n = 0;
    endtask

    task automatic tx(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
    endtask

    // Idle cycles with bit_in still toggling (must be ignored)
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = (i % 7 != 0);
        end
    endtask

    task automatic tx_flag();
        tx(1'b0);
        for (int i = 0; i < 6; i++) tx(1'b1);
        tx(1'b0);
    endtask

    // Send exp[0..n-1] with a zero stuffed after every five ones
    task automatic tx_payload(input int n, input bit gaps);
        int run = 0;
        for (int i = 0; i < n; i++) begin
            tx(exp[i]);
            run = exp[i] ? run + 1 : 0;
            if (run == 5) begin
                tx(1'b0);
                run = 0;
            end
            if (gaps && (i % 3 == 2)) idle(2);
        end
    endtask

    task automatic compare_stream(input int n, input string req);
        chk(got_n == n, req, got_n, n);
        for (int i = 0; i < n && i < got_n; i++)
            chk(got[i] == exp[i], req, got[i], exp[i]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(in_sync == 1'b0, "R1 in_sync", in_sync, 0);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(rx_shift == 8'h00, "R1 rx_shift", rx_shift, 0);
        chk({flag_seen, abort_seen, eop_seen} == 3'b000, "R1 events",
            {flag_seen, abort_seen, eop_seen}, 0);
    endtask

    // No flag yet: nothing may be delivered (R4); disabled cycles ignored (R9)
    task automatic t_hunt();
        logic [23:0] pat = 24'hA5C396;
        clear_mon();
        for (int i = 0; i < 24; i++) begin
            tx(pat[i]);
            if (i % 5 == 4) idle(3);
        end
        idle(1);
        bit_in = 1'b0; @(negedge clk);
        for (int i = 0; i < 6; i++) begin bit_in = 1'b1; @(negedge clk); end
        bit_in = 1'b0; @(negedge clk);
        idle(3);
        chk(got_n == 0, "R4 hunt delivers", got_n, 0);
        chk(in_sync == 1'b0, "R9 flag with bit_en low", in_sync, 0);
        chk(flag_n == 0, "R9 no pulse without bit_en", flag_n, 0);
    endtask

    // Complete frame: opening flag, payload, closing flag, two idle flags
    task automatic t_frame(input logic [31:0] vec, input int n, input bit gaps);
        logic [7:0] want;
        for (int i = 0; i < n; i++) exp[i] = vec[i];
        clear_mon();
        tx_flag();
        tx_payload(n, gaps);
        tx_flag(); tx_flag(); tx_flag();
        idle(4);
        chk(in_sync == 1'b1, "R3 sync after flag", in_sync, 1);
        chk(flag_n == 4, "R3 flag pulses", flag_n, 4);
        compare_stream(n, gaps ? "R9 R2 R7 gapped frame" : "R2 R7 frame");
        for (int k = 0; k < 8; k++) want[k] = exp[n - 8 + k];
        chk(rx_shift == want, "R10 shift contents", rx_shift, want);
    endtask

    // Flags only: nothing delivered
    task automatic t_empty();
        clear_mon();
        tx_flag(); tx_flag(); tx_flag(); tx_flag();
        idle(4);
        chk(got_n == 0, "R7 back-to-back flags", got_n, 0);
        chk(flag_n == 4, "R3 idle flags", flag_n, 4);
    endtask

    // Normal mode long run: abort, hunt, pending bits lost (R5)
    task automatic t_abort();
        loop_mode = 1'b0;
        clear_mon();
        tx(1'b1); tx(1'b0); tx(1'b1); tx(1'b0);
        for (int i = 0; i < 7; i++) tx(1'b1);
        for (int i = 0; i < 14; i++) tx(i[0]);
        idle(4);
        chk(abort_n == 1, "R5 abort pulse", abort_n, 1);
        chk(eop_n == 0, "R5 no eop in normal mode", eop_n, 0);
        chk(in_sync == 1'b0, "R5 back to hunt", in_sync, 0);
        chk(got_n == 0, "R5 pending discarded", got_n, 0);
    endtask

    // Loop mode long run: end-of-poll, stays synced, run and its zero dropped
    task automatic t_eop();
        logic [15:0] d2 = 16'hF7C1;
        loop_mode = 1'b1;
        clear_mon();
        tx_flag();
        tx(1'b0); tx(1'b1); tx(1'b1); tx(1'b0);
        for (int i = 0; i < 9; i++) tx(1'b1);
        tx(1'b0);
        for (int i = 0; i < 16; i++) exp[i] = d2[i];
        tx_payload(16, 1'b0);
        tx_flag(); tx_flag(); tx_flag();
        idle(4);
        chk(eop_n == 1, "R6 eop pulse", eop_n, 1);
        chk(abort_n == 0, "R6 no abort in loop mode", abort_n, 0);
        chk(in_sync == 1'b1, "R6 stays synced", in_sync, 1);
        compare_stream(16, "R11 R6 stream after long run");
        loop_mode = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end

    initial begin
        got_n = 0; flag_n = 0; abort_n = 0; eop_n = 0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_hunt();
        t_frame(32'h7E3F_F81F, 32, 1'b0);
        t_frame(32'h0000_FFFF, 16, 1'b1);
        t_empty();
        t_abort();
        t_frame(32'hC3B7_7DE9, 24, 1'b0);
        t_eop();
        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end

endmodule